// File: doc/BRIEF.md
# Payload Burst Flow Controller

This block moves a payload of arbitrary length, counted in 64-bit words, through an input FIFO and an output FIFO that are each much smaller than the payload. A start pulse captures a source byte address, a destination byte address and a word count. From then on, the block watches two levels and acts on them. One is the free space in the input FIFO, which feeds a processing stage. The other is the fill level of the output FIFO, which that stage fills. The block issues burst requests to a memory master port to keep the input FIFO topped up and the output FIFO drained.

Reads and writes are interleaved as the two levels allow. A read is issued once the input FIFO can take a full four-word burst. It is shortened only at the end of the payload. A write is issued once four words have built up in the output FIFO, or once the whole remainder of the payload is waiting there. The master port sees one request at a time, held until it is acknowledged. When a write and a read are both eligible, the write goes first, so the processing stage is never blocked by a full output FIFO. The read and write pointers each advance by eight bytes per word, independently of each other. A done flag reports that every word has been fetched and every word has been stored.

Top module: `burst_flow_ctrl`

## Requirements
- R1: While reset is held and right after it, req_valid, busy and done are all 0.
- R2: A read request (req_write = 0) has req_len = min(4, words still to read), is issued only when in_free sampled at the deciding edge is at least req_len, and carries req_addr = src_addr + 8 × (words already read).
- R3: A write request (req_write = 1) has req_len = min(4, words still to write), is issued only when out_level sampled at the deciding edge is at least req_len, and carries req_addr = dst_addr + 8 × (words already written).
- R4: When a write and a read are both eligible at the same deciding edge, the write is issued. No request is issued when neither is eligible.
- R5: At most one request is outstanding. While req_valid = 1 and req_ack = 0, req_valid, req_write, req_addr and req_len hold their values. After an edge with req_valid = 1 and req_ack = 1, req_valid is 0.
- R6: Over one payload the read bursts add up to exactly length words, and so do the write bursts. No burst runs past the remaining count.
- R7: busy is 1 from the edge after an accepted start until completion. done rises, with busy falling, only after every word has been read and written. done then stays 1 with no request until the next start, which clears it.
- R8: A start pulse while busy = 1 has no effect. The addresses, length and progress of the running payload are unchanged.
- R9: A start with length = 0 ends with done = 1 within two cycles and issues no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches a payload when idle |
| src_addr | input | 32 | Byte address of the first payload word to read |
| dst_addr | input | 32 | Byte address of the first result word to write |
| length | input | 16 | Payload size in 64-bit words |
| in_free | input | 6 | Free entries in the input FIFO |
| out_level | input | 6 | Words held in the output FIFO |
| req_ack | input | 1 | Master port has completed the presented burst |
| req_valid | output | 1 | A burst request is presented |
| req_write | output | 1 | 1 = write burst to memory, 0 = read burst from memory |
| req_addr | output | 32 | Byte address of the burst's first word |
| req_len | output | 3 | Burst length in words, 1 to 4 |
| busy | output | 1 | A payload is in progress |
| done | output | 1 | The last payload finished; held until the next start |

## Verification
The bench goes after final bursts of one to three words on both sides, and the trap is a sizer that always asks for four words: it would over-read the source or stall forever waiting for output that never arrives. It creates cycles where output data accumulates during an outstanding read, so that a write and a read become eligible together. An arbiter with the wrong priority shows up there as a read issued against a deciding edge where the write was eligible. It lengthens acknowledge delays, which exposes a request that changes or drops before its handshake. It also pulses start in the middle of a run, so a controller that reloads its pointers would write to the wrong addresses or miscount. Zero-length and single-word payloads check that done neither fires early nor waits forever.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2
    } bfc_state_e;

    localparam int CH_RD = 0;
    localparam int CH_WR = 1;

endpackage

// File: rtl/bfc_burst_sizer.sv
// Sizes the next burst of one direction and decides whether the FIFO side
// has room (read) or data (write) for it.
module bfc_burst_sizer #(
    parameter int LEN_W  = 16,
    parameter int LVL_W  = 6,
    parameter int BURST  = 4,
    parameter int BLEN_W = $clog2(BURST + 1)
) (
    input  logic [LEN_W-1:0]  left_i,
    input  logic [LVL_W-1:0]  room_i,
    output logic [BLEN_W-1:0] len_o,
    output logic              elig_o
);

    logic [LEN_W-1:0] len_ext;

    always_comb begin
        if (left_i >= LEN_W'(BURST)) begin
            len_o = BLEN_W'(BURST);
        end else begin
            len_o = left_i[BLEN_W-1:0];
        end
        len_ext = LEN_W'(len_o);
        elig_o  = (left_i != '0) && (LEN_W'(room_i) >= len_ext);
    end

endmodule

// File: rtl/bfc_stream_ptr.sv
// Address and remaining-word tracker for one transfer direction.
module bfc_stream_ptr #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int BLEN_W     = 3,
    parameter int WORD_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  total_i,
    input  logic              adv_i,
    input  logic [BLEN_W-1:0] step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  left_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
    } ptr_t;

    ptr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.addr = base_i;
            s_d.left = total_i;
        end else if (adv_i) begin
            s_d.addr = s_q.addr + (ADDR_W'(step_i) * ADDR_W'(WORD_BYTES));
            s_d.left = s_q.left - LEN_W'(step_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_o = s_q.addr;
    assign left_o = s_q.left;

    AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> (LEN_W'(step_i) <= s_q.left)); // R6

endmodule

// File: rtl/bfc_arbiter.sv
// Picks one candidate burst; a write candidate wins over a read candidate.
module bfc_arbiter #(
    parameter int ADDR_W = 32,
    parameter int BLEN_W = 3
) (
    input  logic              rd_elig_i,
    input  logic [BLEN_W-1:0] rd_len_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              wr_elig_i,
    input  logic [BLEN_W-1:0] wr_len_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic              pick_valid_o,
    output logic              pick_write_o,
    output logic [BLEN_W-1:0] pick_len_o,
    output logic [ADDR_W-1:0] pick_addr_o
);

    always_comb begin
        pick_valid_o = wr_elig_i || rd_elig_i;
        pick_write_o = wr_elig_i;
        if (wr_elig_i) begin
            pick_len_o  = wr_len_i;
            pick_addr_o = wr_addr_i;
        end else begin
            pick_len_o  = rd_len_i;
            pick_addr_o = rd_addr_i;
        end
    end

endmodule

// File: rtl/burst_flow_ctrl.sv
module burst_flow_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LVL_W      = 6,
    parameter int BURST      = 4,
    parameter int WORD_BYTES = 8,
    localparam int BLEN_W    = $clog2(BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [LEN_W-1:0]  length,
    input  logic [LVL_W-1:0]  in_free,
    input  logic [LVL_W-1:0]  out_level,
    input  logic              req_ack,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BLEN_W-1:0] req_len,
    output logic              busy,
    output logic              done
);

    import bfc_pkg::*;

    typedef struct packed {
        bfc_state_e        st;
        logic              done;
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [BLEN_W-1:0] len;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [ADDR_W-1:0] ch_addr [2];
    logic [LEN_W-1:0]  ch_left [2];
    logic [BLEN_W-1:0] ch_len  [2];
    logic [1:0]        ch_elig;
    logic [1:0]        ch_adv;
    logic              ch_load;

    logic              pick_valid;
    logic              pick_write;
    logic [BLEN_W-1:0] pick_len;
    logic [ADDR_W-1:0] pick_addr;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        bfc_stream_ptr #(
            .ADDR_W    (ADDR_W),
            .LEN_W     (LEN_W),
            .BLEN_W    (BLEN_W),
            .WORD_BYTES(WORD_BYTES)
        ) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (ch_load),
            .base_i ((c == CH_RD) ? src_addr : dst_addr),
            .total_i(length),
            .adv_i  (ch_adv[c]),
            .step_i (s_q.len),
            .addr_o (ch_addr[c]),
            .left_o (ch_left[c])
        );

        bfc_burst_sizer #(
            .LEN_W (LEN_W),
            .LVL_W (LVL_W),
            .BURST (BURST),
            .BLEN_W(BLEN_W)
        ) u_size (
            .left_i(ch_left[c]),
            .room_i((c == CH_RD) ? in_free : out_level),
            .len_o (ch_len[c]),
            .elig_o(ch_elig[c])
        );
    end

    bfc_arbiter #(
        .ADDR_W(ADDR_W),
        .BLEN_W(BLEN_W)
    ) u_arb (
        .rd_elig_i   (ch_elig[CH_RD]),
        .rd_len_i    (ch_len[CH_RD]),
        .rd_addr_i   (ch_addr[CH_RD]),
        .wr_elig_i   (ch_elig[CH_WR]),
        .wr_len_i    (ch_len[CH_WR]),
        .wr_addr_i   (ch_addr[CH_WR]),
        .pick_valid_o(pick_valid),
        .pick_write_o(pick_write),
        .pick_len_o  (pick_len),
        .pick_addr_o (pick_addr)
    );

    always_comb begin
        s_d     = s_q;
        ch_load = 1'b0;
        ch_adv  = 2'b00;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_RUN;
                    s_d.done = 1'b0;
                    ch_load  = 1'b1;
                end
            end
            ST_RUN: begin
                if (ch_left[CH_RD] == '0 && ch_left[CH_WR] == '0) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else if (pick_valid) begin
                    s_d.st    = ST_WAIT;
                    s_d.valid = 1'b1;
                    s_d.write = pick_write;
                    s_d.addr  = pick_addr;
                    s_d.len   = pick_len;
                end
            end
            ST_WAIT: begin
                if (req_ack) begin
                    s_d.st    = ST_RUN;
                    s_d.valid = 1'b0;
                    if (s_q.write) begin
                        ch_adv[CH_WR] = 1'b1;
                    end else begin
                        ch_adv[CH_RD] = 1'b1;
                    end
                end
            end
            default: begin
                s_d.st    = ST_IDLE;
                s_d.valid = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, done: 1'b0, valid: 1'b0, write: 1'b0,
                     addr: '0, len: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_valid = s_q.valid;
    assign req_write = s_q.write;
    assign req_addr  = s_q.addr;
    assign req_len   = s_q.len;
    assign busy      = (s_q.st != ST_IDLE);
    assign done      = s_q.done;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_addr)
                                     && $stable(req_len) && $stable(req_write))); // R5
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_valid); // R5
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0 && req_len <= BLEN_W'(BURST))); // R2
    AST_RD_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && !req_write) |-> ($past(in_free) >= LVL_W'(req_len))); // R2
    AST_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && req_write) |-> ($past(out_level) >= LVL_W'(req_len))); // R3
    AST_WR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && $past(ch_elig[CH_WR])) |-> req_write); // R4
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !req_valid)); // R7
    AST_DONE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (ch_left[CH_RD] == '0 && ch_left[CH_WR] == '0)); // R6

endmodule

// File: tb/tb_burst_flow_ctrl.sv
module tb_burst_flow_ctrl;

    localparam int DEPTH = 16;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_addr = '0;
    logic [31:0] dst_addr = '0;
    logic [15:0] length = '0;
    logic [5:0]  in_free = 6'(DEPTH);
    logic [5:0]  out_level = '0;
    logic        req_ack = 1'b0;
    logic        req_valid;
    logic        req_write;
    logic [31:0] req_addr;
    logic [2:0]  req_len;
    logic        busy;
    logic        done;

    always #2.5 clk = ~clk;

    burst_flow_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_addr(src_addr), .dst_addr(dst_addr), .length(length),
        .in_free(in_free), .out_level(out_level), .req_ack(req_ack),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_len(req_len), .busy(busy), .done(done)
    );

    int n_checks = 0;
    int n_fail = 0;
    int ncyc = 0;

    // environment and reference model
    int in_cnt, out_cnt;
    int r_rd_left, r_wr_left;
    longint r_rd_addr, r_wr_addr;
    int xf_pct, ack_pct, n_issue;
    logic drv_start = 1'b0;
    logic p_valid = 1'b0, p_ack = 1'b0, p_write = 1'b0;
    logic [31:0] p_addr = '0;
    int p_len = 0, p_in_free = DEPTH, p_out = 0;

    task automatic chk(input logic ok, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int min4(input int v);
        return (v < 4) ? v : 4;
    endfunction

    task automatic cycle();
        int rl, wl;
        logic we, re;
        @(negedge clk);
        ncyc++;
        if (p_valid && p_ack) begin
            chk(req_valid == 1'b0, "R5 request not dropped after ack", req_valid, 0);
            if (p_write) begin
                out_cnt -= p_len; r_wr_left -= p_len; r_wr_addr += 8 * p_len;
            end else begin
                in_cnt += p_len; r_rd_left -= p_len; r_rd_addr += 8 * p_len;
            end
            chk(r_rd_left >= 0 && r_wr_left >= 0, "R6 burst past remaining count",
                r_rd_left < r_wr_left ? r_rd_left : r_wr_left, 0);
            chk(in_cnt <= DEPTH && out_cnt >= 0, "R2 fifo level broken", in_cnt, out_cnt);
        end else if (p_valid) begin
            chk(req_valid && req_addr == p_addr && 32'(req_len) == 32'(p_len) && req_write == p_write,
                "R5 request changed before ack", req_addr, p_addr);
        end
        if (req_valid && !p_valid) begin
            n_issue++;
            rl = min4(r_rd_left);
            wl = min4(r_wr_left);
            we = (r_wr_left > 0) && (p_out >= wl);
            re = (r_rd_left > 0) && (p_in_free >= rl);
            if (!we && !re) begin
                chk(1'b0, "R4 request with nothing eligible", req_write, -1);
            end else begin
                chk(req_write == we, "R4 write priority", req_write, we);
                if (we) begin
                    chk(int'(req_len) == wl, "R3 write length", req_len, wl);
                    chk(longint'(req_addr) == (r_wr_addr & 64'hFFFF_FFFF), "R3 write address", req_addr, r_wr_addr);
                end else begin
                    chk(int'(req_len) == rl, "R2 read length", req_len, rl);
                    chk(longint'(req_addr) == (r_rd_addr & 64'hFFFF_FFFF), "R2 read address", req_addr, r_rd_addr);
                end
            end
        end
        p_valid = req_valid; p_write = req_write; p_addr = req_addr; p_len = int'(req_len);
        if (in_cnt > 0 && out_cnt < DEPTH && int'($urandom % 100) < xf_pct) begin
            in_cnt--; out_cnt++;
        end
        in_free = 6'(DEPTH - in_cnt);
        out_level = 6'(out_cnt);
        p_in_free = DEPTH - in_cnt;
        p_out = out_cnt;
        req_ack = req_valid && (int'($urandom % 100) < ack_pct);
        p_ack = req_ack;
        start = drv_start;
        drv_start = 1'b0;
    endtask

    task automatic run(input logic [31:0] s, input logic [31:0] d, input int len,
                       input int xf, input int ackp, input logic mid_start);
        int k;
        src_addr = s; dst_addr = d; length = 16'(len);
        xf_pct = xf; ack_pct = ackp;
        in_cnt = 0; out_cnt = 0; n_issue = 0;
        r_rd_left = len; r_wr_left = len; r_rd_addr = s; r_wr_addr = d;
        drv_start = 1'b1;
        cycle();
        cycle();
        chk(busy == 1'b1 && done == 1'b0, "R7 busy after start", {busy, done}, 2);
        for (k = 0; k < 5000; k++) begin
            if (mid_start && k == 10) begin
                drv_start = 1'b1;
                length = 16'(7);
                src_addr = 32'hDEAD_0000;
                dst_addr = 32'hBEEF_0000;
            end
            if (done) break;
            cycle();
        end
        chk(done == 1'b1 && busy == 1'b0, "R7 done at end", {busy, done}, 1);
        chk(r_rd_left == 0 && r_wr_left == 0, mid_start ? "R8 run disturbed by start" : "R6 all words moved",
            r_rd_left + r_wr_left, 0);
        chk(in_cnt == 0 && out_cnt == 0, "R6 fifos empty at done", in_cnt + out_cnt, 0);
        if (len == 0) chk(n_issue == 0, "R9 requests for empty payload", n_issue, 0);
        for (int j = 0; j < 3; j++) begin
            cycle();
            chk(done == 1'b1 && req_valid == 1'b0, "R7 done held quietly", {done, req_valid}, 2);
        end
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd20240611);
        xf_pct = 50; ack_pct = 50;
        in_cnt = 0; out_cnt = 0;
        repeat (3) @(negedge clk);
        chk(req_valid == 0 && busy == 0 && done == 0, "R1 outputs in reset", {req_valid, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 0 && busy == 0 && done == 0, "R1 outputs after reset", {req_valid, busy, done}, 0);

        run(32'h0000_1000, 32'h0000_8000, 0, 50, 50, 1'b0);   // R9
        run(32'h0000_2000, 32'h0000_9000, 1, 50, 50, 1'b0);
        run(32'h0000_3000, 32'h0000_A000, 3, 80, 30, 1'b0);
        run(32'h0000_4000, 32'h0000_B000, 4, 100, 100, 1'b0);
        run(32'h0000_5000, 32'h0000_C000, 5, 20, 70, 1'b0);
        run(32'hFFFF_FF00, 32'h0001_0000, 37, 90, 20, 1'b0);
        run(32'h0010_0000, 32'h0020_0000, 50, 60, 40, 1'b1);   // R8
        for (int t = 0; t < 8; t++) begin
            run($urandom & 32'hFFFF_FFF8, $urandom & 32'hFFFF_FFF8,
                int'($urandom % 60) + 1, int'($urandom % 90) + 10,
                int'($urandom % 90) + 10, 1'b0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (ncyc > WD_LIMIT);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", ncyc, WD_LIMIT);
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule